// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block holds a set of single-bit mutex flags that two processors on a shared 32-bit register bus use to synchronise. Each flag has its own word-sized register. A bus read of that register is an atomic test-and-set: it returns the flag's old value and, when the flag was clear, sets it in the same cycle. The reader then owns the lock. A write of zero to the register clears the flag.

A read-only status word at offset zero reports the size of the bank. The size is an encoded number in its top four bits. Software reads it once to find out how many lock registers follow.

The block has two request ports with identical signals. Port 0 always exists. Port 1 is kept or removed by a parameter. When both ports try to take the same free lock in the same cycle, port 0 wins. Every read answers one cycle after its strobe.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock is free, and both read-data outputs are 32'h0.
- R2: A read of offset 0x000 returns the count code in bits 31:28, with all other bits 0. The code is 1 for 32 locks, 2 for 64, 3 for 128 and 4 for 256.
- R3: Lock i sits at offset 0x100 + 4*i. A read of a free lock returns 32'h0 and leaves the lock taken.
- R4: A read of a taken lock returns 32'h1 and leaves the lock taken.
- R5: Writing 32'h0 to a lock's offset makes it free. Writing any nonzero value leaves a taken lock taken and a free lock free.
- R6: Unmapped offsets have no effect. These are offsets 0x004 to 0x0FC, any offset not a multiple of 4, and offsets at or beyond 0x100 + 4*NUM_LOCKS. A read of one returns 32'h0, and neither a read nor a write of one changes any lock.
- R7: Read data is registered. It holds the result of a read strobe in the cycle after that strobe, and it is 32'h0 in any cycle that does not follow a read strobe on that port.
- R8: When both ports read the same free lock in one cycle, port 0 gets 32'h0 and port 1 gets 32'h1, and the lock is taken. Reads of different free locks in one cycle both get 32'h0.
- R9: When one port releases a lock in the same cycle as the other port reads it, the read returns the state from before that cycle. A taken lock ends up free, and a free lock ends up taken by the reader.
- R10: When a port asserts both its read and write strobes in one cycle, the read is performed and the write is ignored.
- R11: When the second port is disabled by parameter (P1_EN = 0), its inputs have no effect on any lock and its read data stays 32'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | ADDR_W | Port 0 byte offset |
| p0_rd | input | 1 | Port 0 read strobe (read is a test-and-set on lock offsets) |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_wdata | input | 32 | Port 0 write data (zero releases) |
| p0_rdata | output | 32 | Port 0 registered read data |
| p1_addr | input | ADDR_W | Port 1 byte offset |
| p1_rd | input | 1 | Port 1 read strobe |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 registered read data |

## Verification
The bench targets the cycles in which both ports touch the same lock.

- **Simultaneous grab.** A design without a fixed priority would hand the lock to both ports, or to neither.
- **Same-cycle release.** A design that let the release win would read back a stale 0 and give away a lock that is still owned.
- **Address edges.** The bench reads the last lock, the first word past it and a misaligned offset inside the lock window. An off-by-one decoder would alias those onto a real lock and take it.
- **Other cases.** The bench also writes nonzero data, strobes read and write together on one port, and drives the removed second port. A design that releases on any write, or that still listens to the removed port, would show a lock in the wrong state on the next probe.

// File: rtl/hwlock_pkg.sv
`timescale 1ns/1ps
package hwlock_pkg;

    localparam int DATA_W    = 32;
    localparam int LOCK_BASE = 32'h100;

    // What a single bus access targets
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_LOCK   = 2'd2
    } acc_kind_e;

    // Decoded request of one port for one cycle
    typedef struct packed {
        acc_kind_e kind;  // target of the access
        logic      rd;    // read strobe (test-and-set on a lock)
        logic      rel;   // release of the selected lock
    } port_req_t;

    // Size code reported in the top nibble of the status word
    function automatic logic [3:0] count_code(input int n);
        case (n)
            32:      return 4'd1;
            64:      return 4'd2;
            128:     return 4'd3;
            256:     return 4'd4;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input int n);
        return {count_code(n), {(DATA_W-4){1'b0}}};
    endfunction

    // One past the last mapped lock offset
    function automatic int lock_end(input int n);
        return LOCK_BASE + 4 * n;
    endfunction

endpackage

// File: rtl/hwlock_port_decode.sv
`timescale 1ns/1ps
module hwlock_port_decode
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    output port_req_t            req,
    output logic [NUM_LOCKS-1:0] sel
);

    localparam int LIDX_W = $clog2(NUM_LOCKS);
    localparam int END_OF = lock_end(NUM_LOCKS);

    logic [31:0]       addr_w;
    logic              aligned;
    logic              hit_status;
    logic              hit_lock;
    logic [LIDX_W-1:0] lidx;

    always_comb begin
        addr_w     = 32'(addr);
        aligned    = (addr[1:0] == 2'b00);
        hit_status = (addr_w == 32'h0);
        hit_lock   = aligned && (addr_w >= 32'(LOCK_BASE)) && (addr_w < 32'(END_OF));
        lidx       = LIDX_W'((addr_w - 32'(LOCK_BASE)) >> 2);
    end

    // One-hot lock select, empty outside the lock window
    always_comb begin
        sel = '0;
        if (hit_lock) begin
            sel = NUM_LOCKS'(1) << lidx;
        end
    end

    always_comb begin
        req      = '0;
        req.rd   = rd;
        req.kind = hit_status ? ACC_STATUS : (hit_lock ? ACC_LOCK : ACC_NONE);
        // A combined read and write performs only the read
        req.rel  = wr && !rd && hit_lock && (wdata == '0);
    end

endmodule

// File: rtl/hwlock_state.sv
`timescale 1ns/1ps
module hwlock_state
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  port_req_t            req0,
    input  logic [NUM_LOCKS-1:0] sel0,
    input  port_req_t            req1,
    input  logic [NUM_LOCKS-1:0] sel1,
    output logic [NUM_LOCKS-1:0] held_q,
    output logic                 seen0,
    output logic                 seen1
);

    logic                 lk_rd0;
    logic                 lk_rd1;
    logic [NUM_LOCKS-1:0] take0;
    logic [NUM_LOCKS-1:0] take1;
    logic [NUM_LOCKS-1:0] rel_v;
    logic [NUM_LOCKS-1:0] held_d;

    always_comb begin
        lk_rd0 = req0.rd && (req0.kind == ACC_LOCK);
        lk_rd1 = req1.rd && (req1.kind == ACC_LOCK);
        // Port 0 has priority on a free lock
        take0  = lk_rd0 ? (sel0 & ~held_q) : '0;
        take1  = lk_rd1 ? (sel1 & ~held_q & ~take0) : '0;
        rel_v  = (req0.rel ? sel0 : '0) | (req1.rel ? sel1 : '0);
        // Value each reader observes: prior state, port 1 also sees port 0's grab
        seen0  = |(sel0 & held_q);
        seen1  = |(sel1 & (held_q | take0));
    end

    // Per-lock next state: a grab beats a release in the same cycle
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        always_comb begin
            held_d[i] = take0[i] | take1[i] | (held_q[i] & ~rel_v[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

endmodule

// File: rtl/hwlock_rdata.sv
`timescale 1ns/1ps
module hwlock_rdata
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  port_req_t         req,
    input  logic              lock_bit,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (req.rd) begin
            case (req.kind)
                ACC_STATUS: rdata_d = STATUS_VAL;
                ACC_LOCK:   rdata_d = {{(DATA_W-1){1'b0}}, lock_bit};
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rdata_d;
        end
    end

endmodule

// File: rtl/hwlock_bank.sv
`timescale 1ns/1ps
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12,
    parameter bit P1_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_rd,
    input  logic              p0_wr,
    input  logic [31:0]       p0_wdata,
    output logic [31:0]       p0_rdata,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_rd,
    input  logic              p1_wr,
    input  logic [31:0]       p1_wdata,
    output logic [31:0]       p1_rdata
);

    port_req_t            req0;
    port_req_t            req1;
    logic [NUM_LOCKS-1:0] sel0;
    logic [NUM_LOCKS-1:0] sel1;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 seen0;
    logic                 seen1;

    hwlock_port_decode #(
        .NUM_LOCKS (NUM_LOCKS),
        .ADDR_W    (ADDR_W)
    ) u_dec0 (
        .addr  (p0_addr),
        .rd    (p0_rd),
        .wr    (p0_wr),
        .wdata (p0_wdata),
        .req   (req0),
        .sel   (sel0)
    );

    hwlock_rdata #(
        .NUM_LOCKS (NUM_LOCKS)
    ) u_rd0 (
        .clk      (clk),
        .rst      (rst),
        .req      (req0),
        .lock_bit (seen0),
        .rdata    (p0_rdata)
    );

    if (P1_EN) begin : g_port1
        hwlock_port_decode #(
            .NUM_LOCKS (NUM_LOCKS),
            .ADDR_W    (ADDR_W)
        ) u_dec1 (
            .addr  (p1_addr),
            .rd    (p1_rd),
            .wr    (p1_wr),
            .wdata (p1_wdata),
            .req   (req1),
            .sel   (sel1)
        );

        hwlock_rdata #(
            .NUM_LOCKS (NUM_LOCKS)
        ) u_rd1 (
            .clk      (clk),
            .rst      (rst),
            .req      (req1),
            .lock_bit (seen1),
            .rdata    (p1_rdata)
        );
    end else begin : g_no_port1
        assign req1     = '0;
        assign sel1     = '0;
        assign p1_rdata = '0;
    end

    hwlock_state #(
        .NUM_LOCKS (NUM_LOCKS)
    ) u_state (
        .clk    (clk),
        .rst    (rst),
        .req0   (req0),
        .sel0   (sel0),
        .req1   (req1),
        .sel1   (sel1),
        .held_q (lock_q),
        .seen0  (seen0),
        .seen1  (seen1)
    );

endmodule

// File: rtl/hwlock_bank_sva.sv
`timescale 1ns/1ps
module hwlock_bank_sva #(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    p0_addr,
    input logic                 p0_rd,
    input logic                 p0_wr,
    input logic [31:0]          p0_wdata,
    input logic [31:0]          p0_rdata,
    input logic [ADDR_W-1:0]    p1_addr,
    input logic                 p1_rd,
    input logic [31:0]          p1_rdata,
    input logic [NUM_LOCKS-1:0] lock_q
);

    localparam int LIDX_W = $clog2(NUM_LOCKS);
    localparam logic [3:0] EXP_CODE = (NUM_LOCKS == 32)  ? 4'd1 :
                                      (NUM_LOCKS == 64)  ? 4'd2 :
                                      (NUM_LOCKS == 128) ? 4'd3 : 4'd4;

    logic              in0;
    logic [LIDX_W-1:0] idx0;

    always_comb begin
        in0  = (p0_addr[1:0] == 2'b00) && (32'(p0_addr) >= 32'h100) &&
               (32'(p0_addr) < 32'h100 + 32'(4 * NUM_LOCKS));
        idx0 = LIDX_W'((32'(p0_addr) - 32'h100) >> 2);
    end

    a_r1_free_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lock_q == '0));

    a_r2_status_code: assert property (@(posedge clk) disable iff (rst)
        (p0_rd && (p0_addr == '0)) |=> (p0_rdata == {EXP_CODE, 28'h0}));

    a_r2_spare_bits: assert property (@(posedge clk) disable iff (rst)
        p0_rdata[27:1] == 27'h0);

    a_r3_grab_sets: assert property (@(posedge clk) disable iff (rst)
        (p0_rd && in0) |=> (p0_rdata[0] || lock_q[$past(idx0)]));

    a_r5_release_clears: assert property (@(posedge clk) disable iff (rst)
        (p0_wr && !p0_rd && in0 && (p0_wdata == 32'h0) && !p1_rd) |=> !lock_q[$past(idx0)]);

    a_r6_no_set_without_read: assert property (@(posedge clk) disable iff (rst)
        (!p0_rd && !p1_rd) |=> ((lock_q & ~$past(lock_q)) == '0));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !p0_rd |=> (p0_rdata == 32'h0));

    a_r8_port1_loses: assert property (@(posedge clk) disable iff (rst)
        (p0_rd && p1_rd && in0 && (p0_addr == p1_addr)) |=> (p1_rdata == 32'h1));

endmodule

bind hwlock_bank hwlock_bank_sva #(
    .NUM_LOCKS (NUM_LOCKS),
    .ADDR_W    (ADDR_W)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .p0_addr  (p0_addr),
    .p0_rd    (p0_rd),
    .p0_wr    (p0_wr),
    .p0_wdata (p0_wdata),
    .p0_rdata (p0_rdata),
    .p1_addr  (p1_addr),
    .p1_rd    (p1_rd),
    .p1_rdata (p1_rdata),
    .lock_q   (lock_q)
);

// File: tb/hwlock_bank_tb.sv
`timescale 1ns/1ps
module hwlock_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    int          n_chk = 0;
    int          n_bad = 0;

    // Main instance: 32 locks, both ports
    logic [11:0] a0 = '0, a1 = '0;
    logic        rd0 = 0, wr0 = 0, rd1 = 0, wr1 = 0;
    logic [31:0] d0 = '0, d1 = '0;
    logic [31:0] q0, q1;

    // Second instance: 64 locks, port 1 removed
    logic [11:0] ca0 = '0, ca1 = '0;
    logic        crd0 = 0, cwr0 = 0, crd1 = 0, cwr1 = 0;
    logic [31:0] cd0 = '0, cd1 = '0;
    logic [31:0] cq0, cq1;

    always #4 clk = ~clk;

    hwlock_bank #(.NUM_LOCKS(32), .ADDR_W(12), .P1_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst),
        .p0_addr(a0), .p0_rd(rd0), .p0_wr(wr0), .p0_wdata(d0), .p0_rdata(q0),
        .p1_addr(a1), .p1_rd(rd1), .p1_wr(wr1), .p1_wdata(d1), .p1_rdata(q1)
    );

    hwlock_bank #(.NUM_LOCKS(64), .ADDR_W(12), .P1_EN(1'b0)) dut2_i (
        .clk(clk), .rst(rst),
        .p0_addr(ca0), .p0_rd(crd0), .p0_wr(cwr0), .p0_wdata(cd0), .p0_rdata(cq0),
        .p1_addr(ca1), .p1_rd(crd1), .p1_wr(cwr1), .p1_wdata(cd1), .p1_rdata(cq1)
    );

    function automatic logic [11:0] la(input int i);
        return 12'(32'h100 + 4 * i);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One bus cycle on the main instance; results readable on return
    task automatic bus(input logic [11:0] x0, input logic r0, input logic w0, input logic [31:0] v0,
                       input logic [11:0] x1, input logic r1, input logic w1, input logic [31:0] v1);
        @(negedge clk);
        a0 = x0; rd0 = r0; wr0 = w0; d0 = v0;
        a1 = x1; rd1 = r1; wr1 = w1; d1 = v1;
        @(posedge clk);
        #2;
        rd0 = 0; wr0 = 0; rd1 = 0; wr1 = 0;
    endtask

    task automatic bus2(input logic [11:0] x0, input logic r0, input logic w0, input logic [31:0] v0,
                        input logic [11:0] x1, input logic r1, input logic w1, input logic [31:0] v1);
        @(negedge clk);
        ca0 = x0; crd0 = r0; cwr0 = w0; cd0 = v0;
        ca1 = x1; crd1 = r1; cwr1 = w1; cd1 = v1;
        @(posedge clk);
        #2;
        crd0 = 0; cwr0 = 0; crd1 = 0; cwr1 = 0;
    endtask

    task automatic rd_p0(input logic [11:0] x);
        bus(x, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr_p0(input logic [11:0] x, input logic [31:0] v);
        bus(x, 0, 1, v, 0, 0, 0, 0);
    endtask

    task automatic t_reset;
        check("R1 p0 rdata after reset", q0, 32'h0);
        check("R1 p1 rdata after reset", q1, 32'h0);
        for (int i = 0; i < 32; i++) begin
            rd_p0(la(i));
            check("R1 lock free after reset", q0, 32'h0);
        end
        for (int i = 0; i < 32; i++) wr_p0(la(i), 32'h0);
    endtask

    task automatic t_status;
        rd_p0(12'h000);
        check("R2 status 32 locks", q0, 32'h1000_0000);
        bus(0, 0, 0, 0, 12'h000, 1, 0, 0);
        check("R2 status via port 1", q1, 32'h1000_0000);
    endtask

    task automatic t_take_release;
        rd_p0(la(5));
        check("R3 free lock reads 0", q0, 32'h0);
        rd_p0(la(5));
        check("R4 taken lock reads 1", q0, 32'h1);
        rd_p0(la(5));
        check("R4 taken lock stays taken", q0, 32'h1);
        wr_p0(la(5), 32'h0);
        rd_p0(la(5));
        check("R5 zero write released", q0, 32'h0);
        wr_p0(la(5), 32'h0);
    endtask

    task automatic t_nonzero_write;
        rd_p0(la(7));
        wr_p0(la(7), 32'hFFFF_FFFF);
        rd_p0(la(7));
        check("R5 nonzero write keeps taken", q0, 32'h1);
        wr_p0(la(7), 32'h0);
        wr_p0(la(7), 32'h0000_0001);
        rd_p0(la(7));
        check("R5 nonzero write keeps free", q0, 32'h0);
        wr_p0(la(7), 32'h0);
    endtask

    task automatic t_unmapped;
        rd_p0(12'h004);
        check("R6 gap read 0x004", q0, 32'h0);
        rd_p0(12'h0FC);
        check("R6 gap read 0x0FC", q0, 32'h0);
        rd_p0(12'h101);
        check("R6 misaligned read", q0, 32'h0);
        rd_p0(la(0));
        check("R6 misaligned read took nothing", q0, 32'h0);
        wr_p0(12'h101, 32'h0);
        rd_p0(la(0));
        check("R6 misaligned write released nothing", q0, 32'h1);
        wr_p0(la(0), 32'h0);
        rd_p0(la(31));
        check("R3 last lock reads 0", q0, 32'h0);
        rd_p0(la(32));
        check("R6 past last lock reads 0", q0, 32'h0);
        rd_p0(la(32));
        check("R6 past last lock still 0", q0, 32'h0);
        wr_p0(la(32), 32'h0);
        rd_p0(la(31));
        check("R6 write past end kept last lock", q0, 32'h1);
        wr_p0(la(31), 32'h0);
    endtask

    task automatic t_idle;
        rd_p0(12'h000);
        check("R7 result one cycle after strobe", q0, 32'h1000_0000);
        bus(0, 0, 0, 0, 0, 0, 0, 0);
        check("R7 idle cycle returns 0", q0, 32'h0);
    endtask

    task automatic t_contention;
        bus(la(9), 1, 0, 0, la(9), 1, 0, 0);
        check("R8 port 0 wins", q0, 32'h0);
        check("R8 port 1 loses", q1, 32'h1);
        bus(la(9), 1, 0, 0, la(9), 1, 0, 0);
        check("R8 both see taken p0", q0, 32'h1);
        check("R8 both see taken p1", q1, 32'h1);
        bus(la(10), 1, 0, 0, la(11), 1, 0, 0);
        check("R8 distinct locks p0", q0, 32'h0);
        check("R8 distinct locks p1", q1, 32'h0);
        wr_p0(la(9), 0); wr_p0(la(10), 0); wr_p0(la(11), 0);
    endtask

    task automatic t_read_release;
        rd_p0(la(3));
        bus(la(3), 0, 1, 0, la(3), 1, 0, 0);
        check("R9 reader sees prior taken", q1, 32'h1);
        rd_p0(la(3));
        check("R9 release won on taken lock", q0, 32'h0);
        wr_p0(la(3), 0);
        bus(la(4), 0, 1, 0, la(4), 1, 0, 0);
        check("R9 reader takes free lock", q1, 32'h0);
        rd_p0(la(4));
        check("R9 lock held by reader", q0, 32'h1);
        wr_p0(la(4), 0);
    endtask

    task automatic t_rd_wr_same_port;
        rd_p0(la(6));
        bus(la(6), 1, 1, 0, 0, 0, 0, 0);
        check("R10 combined strobe reads", q0, 32'h1);
        rd_p0(la(6));
        check("R10 write part ignored", q0, 32'h1);
        wr_p0(la(6), 0);
    endtask

    task automatic t_port1_removed;
        bus2(12'h000, 1, 0, 0, 0, 0, 0, 0);
        check("R2 status 64 locks", cq0, 32'h2000_0000);
        bus2(0, 0, 0, 0, la(0), 1, 0, 0);
        check("R11 removed port reads 0", cq1, 32'h0);
        bus2(la(0), 1, 0, 0, 0, 0, 0, 0);
        check("R11 removed port took nothing", cq0, 32'h0);
        bus2(0, 0, 0, 0, la(0), 0, 1, 0);
        bus2(la(0), 1, 0, 0, 0, 0, 0, 0);
        check("R11 removed port released nothing", cq0, 32'h1);
        bus2(la(63), 1, 0, 0, 0, 0, 0, 0);
        check("R3 lock 63 of 64 reads 0", cq0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_status();
        t_take_release();
        t_nonzero_write();
        t_unmapped();
        t_idle();
        t_contention();
        t_read_release();
        t_rd_wr_same_port();
        t_port1_removed();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule